// File: doc/BRIEF.md
# Dual Down-Counting Timer

This peripheral holds two identical down-counting timers behind a plain register bus made of a byte address, a write strobe, write data and combinational read data. Each timer steps its count down on ticks from its own prescaler. When the count steps from one to zero, the timer latches a pending event. What happens on the next tick depends on the mode: a periodic timer reloads from its reload value, a free-running timer wraps to the largest count, and a one-shot timer stays at zero.

Software stops a timer by clearing its control word, writes a start count, and then enables the timer in a separate write. A background reload write changes only the value used at the next reload, so a running period can be retuned without a restart. Each timer drives its own interrupt pin, and a third pin is the OR of the two. A read-only identification window returns fixed bytes so that software can confirm what sits at the base address.

Top module: `dual_countdown_timer`

## Requirements
- R1: After reset, in both timers the start/reload value reads 0, the count reads 0xFFFF, the control word reads 0x20, raw and masked status read 0, and all three interrupt pins are low.
- R2: Only word-aligned addresses (bits 1:0 = 0) are decoded. Timer A's registers sit at byte offsets 0x00 (start/reload value), 0x04 (count), 0x08 (control), 0x0C (event clear), 0x10 (raw status, bit 0), 0x14 (masked status, bit 0) and 0x18 (background reload). Timer B has the same set at 0x20 to 0x38, and a write to one timer never changes the other.
- R3: A write to the start/reload register loads the count in the same clock edge and also sets the reload value.
- R4: A write to the background reload register changes only the reload value. The count keeps stepping from where it was, and the new value is used at the next reload.
- R5: In the control word, bit 7 is enable, bit 6 is periodic, bit 5 is interrupt enable, bits 3:2 are the prescale and bit 1 is 32-bit size. Bit 0 is one-shot and takes priority over bit 6. Prescale 00 gives a tick every enabled cycle, 01 a tick every 16th enabled cycle and 10 or 11 a tick every 256th enabled cycle. The prescaler restarts from zero while the timer is disabled and on a start-value write.
- R6: In periodic mode, a tick at count zero reloads the count from the reload value.
- R7: In free-running mode, a tick at count zero wraps the count to 0xFFFF in 16-bit size or to 0xFFFFFFFF in 32-bit size.
- R8: In one-shot mode, the count stays at zero once it gets there, until software loads it again.
- R9: The raw status bit is set by a tick that takes the count from 1 to 0. A write of any value to the event clear register clears it. The clear register reads as 0.
- R10: Masked status is raw status AND interrupt enable. Each timer's interrupt pin shows its masked status, and the combined pin is high when either one is.
- R11: Clearing the enable bit halts the count at its value. The edge that writes the control word still uses the old enable bit.
- R12: Writes to the count, status and identification registers have no effect.
- R13: Reads at 0xFE0+4*i return byte i of parameter PERIPH_ID (default 0x00142D61), and reads at 0xFF0+4*i return byte i of CELL_ID (default 0xB105F00D), in bits 7:0 with zero above, for i = 0 to 3.
- R14: In 16-bit size, only the low 16 bits of the count are shown, tested for zero and stepped. A start value with upper bits set reads back masked until 32-bit size is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (12) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_t0 | output | 1 | Timer A masked interrupt |
| irq_t1 | output | 1 | Timer B masked interrupt |
| irq_any | output | 1 | OR of both timer interrupts |

## Verification
On every cycle, the embedded assertions check the following: a disabled timer holds its count, a start-value write is captured, a one-shot timer at zero stays there, the raw status rises only on a 1-to-0 step and falls after a clear, and an idle prescaler sits at zero. Only the bench's scenarios can show the rest. That covers the exact tick spacing at each prescale, the reload and wrap values, the background-reload timing, the address map and identification bytes, and the interrupt masking on the pins. A seeded random sweep over modes, sizes, prescales and start values compares counts and status against a step-by-step model held in the bench.

// File: rtl/dct_pkg.sv
package dct_pkg;

  localparam int CW = 32;
  localparam int SW = 16;
  localparam int PW = 8;

  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2
  } run_mode_e;

  typedef enum logic [2:0] {
    RG_LOAD  = 3'd0,
    RG_VALUE = 3'd1,
    RG_CTRL  = 3'd2,
    RG_ICLR  = 3'd3,
    RG_RAW   = 3'd4,
    RG_MASK  = 3'd5,
    RG_BG    = 3'd6,
    RG_NONE  = 3'd7
  } reg_e;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic       ie;
    logic [1:0] pscale;
    logic       wide;
    logic       oneshot;
  } ctrl_t;

  typedef struct packed {
    logic [CW-1:0] count;
    logic          hit;
  } step_t;

  localparam ctrl_t CTRL_RESET = '{en: 1'b0, periodic: 1'b0, ie: 1'b1,
                                   pscale: 2'b00, wide: 1'b0, oneshot: 1'b0};

  function automatic logic [CW-1:0] size_mask(input logic wide);
    return wide ? {CW{1'b1}} : {{(CW-SW){1'b0}}, {SW{1'b1}}};
  endfunction

  function automatic run_mode_e mode_of(input ctrl_t c);
    if (c.oneshot)       return MODE_ONESHOT;
    else if (c.periodic) return MODE_PERIODIC;
    else                 return MODE_FREE;
  endfunction

  // last prescaler phase before a tick: 0, 15 or 255
  function automatic logic [PW-1:0] pre_last(input logic [1:0] ps);
    case (ps)
      2'b00:   return PW'(0);
      2'b01:   return PW'(15);
      default: return PW'(255);
    endcase
  endfunction

  // one counter step on a prescaler tick
  function automatic step_t count_step(input logic [CW-1:0] cnt,
                                       input logic [CW-1:0] reload,
                                       input ctrl_t c);
    step_t r;
    logic [CW-1:0] m, vis;
    m   = size_mask(c.wide);
    vis = cnt & m;
    r.hit = 1'b0;
    if (vis != '0) begin
      r.count = (vis - 1'b1) & m;
      r.hit   = (vis == {{(CW-1){1'b0}}, 1'b1});
    end else begin
      case (mode_of(c))
        MODE_ONESHOT:  r.count = vis;
        MODE_PERIODIC: r.count = reload;
        default:       r.count = m;
      endcase
    end
    return r;
  endfunction

  // ctrl image bits {7,6,5,3,2,1,0}
  function automatic ctrl_t ctrl_from_bits(input logic [6:0] b);
    ctrl_t c;
    c.en       = b[6];
    c.periodic = b[5];
    c.ie       = b[4];
    c.pscale   = b[3:2];
    c.wide     = b[1];
    c.oneshot  = b[0];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_to_bus(input ctrl_t c);
    return {24'd0, c.en, c.periodic, c.ie, 1'b0, c.pscale, c.wide, c.oneshot};
  endfunction

endpackage

// File: rtl/dct_prescaler.sv
module dct_prescaler
  import dct_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       restart,
  input  logic [1:0] ps,
  output logic       tick
);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] last;

  assign last = pre_last(ps);
  // >= keeps a lowered divide from stalling mid-count
  assign tick = run && (phase_q >= last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      phase_q <= '0;
    else if (!run || restart || tick) phase_q <= '0;
    else                              phase_q <= phase_q + 1'b1;
  end

  // R5
  prescale_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (phase_q == '0));

endmodule

// File: rtl/dct_channel.sv
module dct_channel
  import dct_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  reg_e          wr_sel,
  input  logic [CW-1:0] wr_data,
  output logic [CW-1:0] load_o,
  output logic [CW-1:0] value_o,
  output ctrl_t         ctrl_o,
  output logic          raw_o,
  output logic          masked_o
);

  logic [CW-1:0] load_q, cnt_q;
  ctrl_t         ctrl_q;
  logic          raw_q;
  logic          tick, hit;
  logic          ld_we, bg_we, ctl_we, clr_we;
  step_t         nxt;

  assign ld_we  = wr_en && (wr_sel == RG_LOAD);
  assign bg_we  = wr_en && (wr_sel == RG_BG);
  assign ctl_we = wr_en && (wr_sel == RG_CTRL);
  assign clr_we = wr_en && (wr_sel == RG_ICLR);

  dct_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (ctrl_q.en),
    .restart (ld_we),
    .ps      (ctrl_q.pscale),
    .tick    (tick)
  );

  assign nxt = count_step(cnt_q, load_q, ctrl_q);
  assign hit = tick && nxt.hit && !ld_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '1;
      ctrl_q <= CTRL_RESET;
      raw_q  <= 1'b0;
    end else begin
      if (ld_we)      cnt_q <= wr_data;
      else if (tick)  cnt_q <= nxt.count;
      if (ld_we || bg_we) load_q <= wr_data;
      if (ctl_we)
        ctrl_q <= ctrl_from_bits({wr_data[7:5], wr_data[3:0]});
      if (hit)         raw_q <= 1'b1;
      else if (clr_we) raw_q <= 1'b0;
    end
  end

  assign load_o   = load_q;
  assign value_o  = cnt_q & size_mask(ctrl_q.wide);
  assign ctrl_o   = ctrl_q;
  assign raw_o    = raw_q;
  assign masked_o = raw_q & ctrl_q.ie;

  // R11
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q.en && !ld_we) |=> $stable(cnt_q));

  // R3
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |=> (cnt_q == $past(wr_data)));

  // R8
  oneshot_rest_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q.oneshot && value_o == '0 && !ld_we && !ctl_we) |=> (value_o == '0));

  // R9
  raw_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(hit));

  // R9
  raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !hit) |=> !raw_q);

  // R4
  bg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_we && !ld_we && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/dual_countdown_timer.sv
module dual_countdown_timer
  import dct_pkg::*;
#(
  parameter int          ADDR_W    = 12,
  parameter logic [31:0] PERIPH_ID = 32'h0014_2D61,
  parameter logic [31:0] CELL_ID   = 32'hB105_F00D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_t0,
  output logic              irq_t1,
  output logic              irq_any
);

  localparam int NCH = 2;
  localparam int HIW = ADDR_W - 5;
  localparam logic [HIW-1:0] ID_PAGE = HIW'(12'hFE0 >> 5);

  logic    aligned, in_timer, in_id, ch;
  reg_e    sel;
  logic [CW-1:0] ch_load  [NCH];
  logic [CW-1:0] ch_value [NCH];
  ctrl_t         ch_ctrl  [NCH];
  logic          ch_raw   [NCH];
  logic          ch_mask  [NCH];

  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign in_timer = aligned && (bus_addr[ADDR_W-1:6] == '0);
  assign in_id    = aligned && (bus_addr[ADDR_W-1:5] == ID_PAGE);
  assign ch       = bus_addr[5];
  assign sel      = reg_e'(bus_addr[4:2]);

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    return idx[2] ? CELL_ID[idx[1:0]*8 +: 8] : PERIPH_ID[idx[1:0]*8 +: 8];
  endfunction

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wr_here;
    assign wr_here = bus_we && in_timer && (ch == 1'(g));
    dct_channel u_ch (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_here),
      .wr_sel   (sel),
      .wr_data  (bus_wdata),
      .load_o   (ch_load[g]),
      .value_o  (ch_value[g]),
      .ctrl_o   (ch_ctrl[g]),
      .raw_o    (ch_raw[g]),
      .masked_o (ch_mask[g])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (in_timer) begin
      case (sel)
        RG_LOAD, RG_BG: bus_rdata = ch_load[ch];
        RG_VALUE:       bus_rdata = ch_value[ch];
        RG_CTRL:        bus_rdata = ctrl_to_bus(ch_ctrl[ch]);
        RG_RAW:         bus_rdata = {31'd0, ch_raw[ch]};
        RG_MASK:        bus_rdata = {31'd0, ch_mask[ch]};
        default:        bus_rdata = '0;
      endcase
    end else if (in_id) begin
      bus_rdata = {24'd0, id_byte(bus_addr[4:2])};
    end
  end

  assign irq_t0  = ch_mask[0];
  assign irq_t1  = ch_mask[1];
  assign irq_any = irq_t0 | irq_t1;

  // R12
  id_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && in_id && !ch_ctrl[0].en && !ch_ctrl[1].en)
      |=> ($stable(ch_value[0]) && $stable(ch_value[1])));

endmodule

// File: tb/dual_countdown_timer_tb.sv
`timescale 1ns/10ps
module dual_countdown_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_t0, irq_t1, irq_any;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dual_countdown_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_t0(irq_t0), .irq_t1(irq_t1), .irq_any(irq_any)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // all tasks start just after a falling edge
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_reg(input string tag, input logic [11:0] a, input logic [31:0] e);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, e);
  endtask

  // independent model: mode 0 free, 1 periodic, 2 one-shot
  task automatic model(input int mode, input bit wide, input logic [31:0] start,
                       input int ticks, output logic [31:0] v, output bit raw);
    logic [31:0] lim;
    lim = wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
    v = start & lim;
    raw = 1'b0;
    for (int k = 0; k < ticks; k++) begin
      if (v == 0) begin
        if (mode == 1) v = start & lim;
        else if (mode == 0) v = lim;
      end else begin
        v = v - 1;
        if (v == 0) raw = 1'b1;
      end
    end
  endtask

  initial begin : wdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, ev;
    bit er;
    void'($urandom(32'd20240611));
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state of both timers
    for (int c = 0; c < 2; c++) begin
      expect_reg("R1 load", 12'(c*32 + 0), 32'h0);
      expect_reg("R1 value", 12'(c*32 + 4), 32'hFFFF);
      expect_reg("R1 ctrl", 12'(c*32 + 8), 32'h20);
      expect_reg("R1 raw", 12'(c*32 + 16), 32'h0);
      expect_reg("R1 masked", 12'(c*32 + 20), 32'h0);
    end
    check("R1 irq pins", {29'd0, irq_t0, irq_t1, irq_any}, 32'h0);

    // R13 identification bytes
    for (int i = 0; i < 4; i++) begin
      expect_reg("R13 periph id", 12'(12'hFE0 + 4*i), {24'd0, 8'(32'h0014_2D61 >> (8*i))});
      expect_reg("R13 cell id", 12'(12'hFF0 + 4*i), {24'd0, 8'(32'hB105_F00D >> (8*i))});
    end

    // R12 read-only registers ignore writes
    wr(12'h004, 32'h1234_5678);
    expect_reg("R12 value write ignored", 12'h004, 32'hFFFF);
    wr(12'h010, 32'h1);
    expect_reg("R12 raw write ignored", 12'h010, 32'h0);
    wr(12'hFE0, 32'hAA);
    expect_reg("R12 id write ignored", 12'hFE0, 32'h61);
    expect_reg("R9 clear reads zero", 12'h00C, 32'h0);

    // R3 / R2 load at timer B leaves timer A untouched
    wr(12'h020, 32'h55);
    expect_reg("R3 value loaded", 12'h024, 32'h55);
    expect_reg("R3 load readback", 12'h020, 32'h55);
    expect_reg("R2 timer A unaffected", 12'h000, 32'h0);
    wr(12'h001, 32'h77);
    expect_reg("R2 misaligned ignored", 12'h000, 32'h0);

    // R14 16-bit view masks upper bits
    wr(12'h000, 32'h0012_3456);
    expect_reg("R14 16-bit view", 12'h004, 32'h3456);
    wr(12'h008, 32'h02);
    expect_reg("R14 32-bit view", 12'h004, 32'h0012_3456);

    // R4 background reload, R6 periodic reload
    wr(12'h008, 32'h0); wr(12'h00C, 32'h0);
    wr(12'h000, 32'd5);
    wr(12'h008, 32'hE2);
    idle(2);
    expect_reg("R4 before bg write", 12'h004, 32'd3);
    wr(12'h018, 32'd10);
    expect_reg("R4 count kept", 12'h004, 32'd2);
    idle(3);
    expect_reg("R6 reload from bg value", 12'h004, 32'd10);
    expect_reg("R9 raw after 1->0", 12'h010, 32'h1);
    check("R10 irq_t0", {31'd0, irq_t0}, 32'h1);

    // R11 disable halts
    wr(12'h008, 32'h62);
    expect_reg("R11 last step", 12'h004, 32'd9);
    idle(20);
    expect_reg("R11 held", 12'h004, 32'd9);
    wr(12'h00C, 32'hDEAD_BEEF);
    expect_reg("R9 clear any value", 12'h010, 32'h0);

    // R7 free-running wraps
    wr(12'h000, 32'd1);
    wr(12'h008, 32'hA0);
    idle(2);
    expect_reg("R7 wrap 16-bit", 12'h004, 32'h0000_FFFF);
    wr(12'h008, 32'h0); wr(12'h00C, 32'h0);
    wr(12'h000, 32'd1);
    wr(12'h008, 32'hA2);
    idle(2);
    expect_reg("R7 wrap 32-bit", 12'h004, 32'hFFFF_FFFF);

    // R8 one-shot rests at zero
    wr(12'h008, 32'h0); wr(12'h00C, 32'h0);
    wr(12'h000, 32'd2);
    wr(12'h008, 32'hE3);
    idle(2);
    expect_reg("R8 reaches zero", 12'h004, 32'h0);
    idle(10);
    expect_reg("R8 stays zero", 12'h004, 32'h0);
    expect_reg("R8 raw set", 12'h010, 32'h1);

    // R5 prescale spacing
    wr(12'h008, 32'h0); wr(12'h00C, 32'h0);
    wr(12'h000, 32'd3); wr(12'h008, 32'hC6);
    idle(15);
    expect_reg("R5 div16 before", 12'h004, 32'd3);
    idle(1);
    expect_reg("R5 div16 tick", 12'h004, 32'd2);
    wr(12'h008, 32'h0);
    wr(12'h000, 32'd3); wr(12'h008, 32'hCA);
    idle(255);
    expect_reg("R5 div256 before", 12'h004, 32'd3);
    idle(1);
    expect_reg("R5 div256 tick", 12'h004, 32'd2);
    wr(12'h008, 32'h0);
    wr(12'h000, 32'd3); wr(12'h008, 32'hCE);
    idle(255);
    expect_reg("R5 code 11 before", 12'h004, 32'd3);
    idle(1);
    expect_reg("R5 code 11 tick", 12'h004, 32'd2);
    wr(12'h008, 32'h0); wr(12'h00C, 32'h0);

    // R10 masking on timer B
    wr(12'h028, 32'h0); wr(12'h02C, 32'h0);
    wr(12'h020, 32'd1);
    wr(12'h028, 32'h82);
    idle(1);
    expect_reg("R10 raw with ie off", 12'h030, 32'h1);
    expect_reg("R10 masked with ie off", 12'h034, 32'h0);
    check("R10 pins with ie off", {30'd0, irq_t1, irq_any}, 32'h0);
    wr(12'h028, 32'h22);
    expect_reg("R10 masked with ie on", 12'h034, 32'h1);
    check("R10 pins with ie on", {29'd0, irq_t0, irq_t1, irq_any}, 32'h3);
    wr(12'h02C, 32'h0);
    check("R9 pins after clear", {30'd0, irq_t1, irq_any}, 32'h0);

    // random sweep: R6 R7 R8 R5 R14 R10
    for (int it = 0; it < 40; it++) begin
      int c, mode, w, ticks, psel;
      bit wide, ie;
      logic [31:0] start, ctl, base;
      c = $urandom_range(0, 1);
      base = c ? 32'h20 : 32'h0;
      mode = $urandom_range(0, 2);
      wide = 1'($urandom_range(0, 1));
      ie = 1'($urandom_range(0, 1));
      psel = $urandom_range(0, 1);
      start = 32'($urandom_range(0, 40));
      if ($urandom_range(0, 1) == 1) start = start | ($urandom & 32'hFFFF_0000);
      w = psel ? $urandom_range(0, 900) : $urandom_range(0, 120);
      ticks = psel ? w / 16 : w;
      ctl = 32'h80 | (mode == 1 ? 32'h40 : 32'h0) | (ie ? 32'h20 : 32'h0)
          | (psel ? 32'h04 : 32'h0) | (wide ? 32'h02 : 32'h0) | (mode == 2 ? 32'h01 : 32'h0);
      wr(12'(base + 8), 32'h0);
      wr(12'(base + 12), 32'h0);
      wr(12'(base), start);
      wr(12'(base + 8), ctl);
      idle(w);
      model(mode, wide, start, ticks, ev, er);
      expect_reg("R6/R7/R8 random count", 12'(base + 4), ev);
      expect_reg("R9 random raw", 12'(base + 16), {31'd0, er});
      expect_reg("R10 random masked", 12'(base + 20), {31'd0, er & ie});
      check("R10 random pins", {30'd0, (c ? irq_t1 : irq_t0), irq_any},
            {30'd0, er & ie, er & ie});
      wr(12'(base + 8), 32'h0);
      wr(12'(base + 12), 32'h0);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule